// File: doc/BRIEF.md
# Parallel Port Handshake and Interrupt Controller

This block is the control plane for two 8-bit parallel ports, called side A and side B. Each side has two control lines. The first control line (C1) is an input, and a chosen transition on it raises a flag. The second control line (C2) can work as an edge-sensitive input or as an output. As an output it can hand-shake with a peripheral, pulse once per port access, or sit at a fixed level. One control byte selects the behaviour of both sides. A separate latch-control byte can make each port's input data be captured on the active C1 transition and held there, instead of being read live.

All interrupt sources meet in a seven-bit flag register, with a matching enable register beside it. Four of the flags come from the control lines. The other three come as one-cycle event pulses from a timer pair and a shift register that live elsewhere. The enable register is written through a set/clear selector bit. Flags are cleared by writing ones, or as a side effect of accessing the port data. A single active-low interrupt line reports any flag that is both set and enabled.

Software reaches the block through a single-cycle register strobe interface with a 4-bit address. Reads are combinational on `bus_rdata`. A read strobe is only needed where the read has side effects. Port A has a second "quiet" address that reaches the same data without any side effect.

Top module: `hsk_port_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, `ca2_out` and `cb2_out` are 1, `ca2_oe` and `cb2_oe` are 0, the flag register (address 0xD) reads 0x00 and the enable register (address 0xE) reads 0x80.
- R2: Control byte (address 0xC) bit 0 selects the side-A C1 edge and bit 4 the side-B C1 edge (1 = rising, 0 = falling). An active transition sets flag bit 1 (A) or bit 4 (B). The opposite transition sets nothing. A set flag stays set until it is cleared.
- R3: The C2 mode field is control bits 3:1 for side A and bits 7:5 for side B. Mode 000 means falling edge, cleared by access. Mode 001 means falling edge, kept on access. Mode 010 means rising edge, cleared by access. Mode 011 means rising edge, kept on access. The C2 flag is bit 0 (A) or bit 3 (B).
- R4: A read or write strobe to address 0x1 is an access to port A, and one to address 0x0 is an access to port B. An access clears that side's C1 flag, and also clears its C2 flag unless the mode is 001 or 011. A write to 0x1 or 0xF loads `pa_out`, and a write to 0x0 loads `pb_out`.
- R5: In C2 mode 100, C2 goes low in the cycle after a port access. It stays low until the cycle after the active C1 transition, and then returns high.
- R6: In C2 mode 101, C2 is low for exactly the one cycle after a port access, and high otherwise.
- R7: In C2 mode 110, C2 drives low; in mode 111, C2 drives high. The output enable for C2 is 1 in every mode whose top bit is 1, and 0 in the input modes.
- R8: Reads and writes at address 0xF reach port A without clearing any flag and without disturbing the C2 output.
- R9: Latch-control (address 0xB) bit 0 (A) and bit 1 (B) make port reads return the input captured at the most recent active C1 transition. When the bit is 0, reads return the live input.
- R10: A write to address 0xE with bit 7 = 1 sets every enable whose bit in 6:0 is 1. With bit 7 = 0, the same write clears those enables instead. A zero bit leaves its enable unchanged. The register reads back with bit 7 = 1.
- R11: The flag register holds T1 (`t1_evt`) at bit 6, T2 (`t2_evt`) at bit 5, CB1 at bit 4, CB2 at bit 3, SR (`sr_evt`) at bit 2, CA1 at bit 1 and CA2 at bit 0. Writing ones to 0xD clears those flags. Bit 7 reads 1 exactly when some set flag is also enabled.
- R12: `irq_n` is low exactly when flag register bit 7 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_rd | input | 1 | Single-cycle register read strobe (for read side effects) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output register |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output register |
| ca1_in | input | 1 | Side A C1 control input |
| ca2_in | input | 1 | Side A C2 line sampled as input |
| ca2_out | output | 1 | Side A C2 output level |
| ca2_oe | output | 1 | Side A C2 output enable |
| cb1_in | input | 1 | Side B C1 control input |
| cb2_in | input | 1 | Side B C2 line sampled as input |
| cb2_out | output | 1 | Side B C2 output level |
| cb2_oe | output | 1 | Side B C2 output enable |
| t1_evt | input | 1 | Timer 1 event pulse |
| t2_evt | input | 1 | Timer 2 event pulse |
| sr_evt | input | 1 | Shift register event pulse |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
The hardest situation to reach is the interplay of timing between a port access and the C2 output. In handshake mode the line must stay low across idle cycles and release only on the C1 transition of the selected polarity. The opposite transition must leave it alone. The bench gets there by first setting C1 to its inactive level, then issuing the access, then holding for several cycles before it drives the active transition. It samples C2 on each falling clock edge around those events. A similar case is the kept-versus-cleared behaviour of the C2 flag. The bench raises that flag, issues a port access in each of the four input modes, and reads the flag register afterwards.

// File: rtl/hsk_pkg.sv
// Shared constants and types for the handshake port controller.
// Assumes an 8-bit register interface and seven interrupt sources.
package hsk_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;
    localparam int NFLAG  = 7;
    localparam int NSIDE  = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_PORTB   = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_PORTA   = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_LATCH   = 4'hB;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_FLAG    = 4'hD;
    localparam logic [ADDR_W-1:0] ADR_ENAB    = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_PORTA_Q = 4'hF;

    // Flag bit positions (software decodes these)
    localparam int FL_CA2 = 0;
    localparam int FL_CA1 = 1;
    localparam int FL_SR  = 2;
    localparam int FL_CB2 = 3;
    localparam int FL_CB1 = 4;
    localparam int FL_T2  = 5;
    localparam int FL_T1  = 6;

    typedef enum logic [2:0] {
        C2_IN_FALL_CLR  = 3'b000,
        C2_IN_FALL_KEEP = 3'b001,
        C2_IN_RISE_CLR  = 3'b010,
        C2_IN_RISE_KEEP = 3'b011,
        C2_OUT_HSK      = 3'b100,
        C2_OUT_PULSE    = 3'b101,
        C2_OUT_LOW      = 3'b110,
        C2_OUT_HIGH     = 3'b111
    } c2_mode_e;
endpackage

// File: rtl/hsk_edge_det.sv
// Single-line transition detector with selectable polarity.
// Assumes the input is already synchronous to clk. No edge is reported
// until one sample has been taken after reset, so the line's level at
// reset never counts as a transition.
module hsk_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic rise_sel,
    output logic edge_hit
);
    logic prev_q;
    logic primed_q;

    // Keep the previous sample and note that it is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b1;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= sig;
            primed_q <= 1'b1;
        end
    end

    // Report the selected transition between the stored and current sample
    always_comb begin
        if (rise_sel) edge_hit = primed_q & sig & ~prev_q;
        else          edge_hit = primed_q & ~sig & prev_q;
    end
endmodule

// File: rtl/hsk_side.sv
// Control for one port side: C1 edge detection, C2 input or output mode,
// input data latching, and the flag set/clear requests for this side.
// Assumes 'access' is a single-cycle strobe for the side's handshake address.
module hsk_side
    import hsk_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c1_in,
    input  logic              c2_in,
    input  logic              c1_rise,
    input  logic [2:0]        c2_mode,
    input  logic              latch_en,
    input  logic [PORT_W-1:0] port_in,
    input  logic              access,
    output logic              c1_set,
    output logic              c2_set,
    output logic              c1_clr,
    output logic              c2_clr,
    output logic              c2_out,
    output logic              c2_oe,
    output logic [PORT_W-1:0] port_val
);
    logic              c1_hit;
    logic              c2_hit;
    logic              c2_q;
    logic              c2_d;
    logic [PORT_W-1:0] cap_q;
    c2_mode_e          mode;

    assign mode = c2_mode_e'(c2_mode);

    hsk_edge_det u_c1_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (c1_in),
        .rise_sel(c1_rise),
        .edge_hit(c1_hit)
    );

    hsk_edge_det u_c2_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (c2_in),
        .rise_sel(c2_mode[1]),
        .edge_hit(c2_hit)
    );

    // Flag requests: C2 only flags in input modes; keep-modes survive access
    always_comb begin
        c1_set = c1_hit;
        c2_set = c2_hit & ~c2_mode[2];
        c1_clr = access;
        c2_clr = access & ((mode != C2_IN_FALL_KEEP) && (mode != C2_IN_RISE_KEEP));
    end

    // Next C2 output level per mode
    always_comb begin
        case (mode)
            C2_OUT_HSK:   c2_d = access ? 1'b0 : (c1_hit ? 1'b1 : c2_q);
            C2_OUT_PULSE: c2_d = ~access;
            C2_OUT_LOW:   c2_d = 1'b0;
            default:      c2_d = 1'b1;
        endcase
    end

    // C2 output register
    always_ff @(posedge clk) begin
        if (!rst_n) c2_q <= 1'b1;
        else        c2_q <= c2_d;
    end

    // Capture port input on the active C1 transition
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (c1_hit) cap_q <= port_in;
    end

    assign c2_out   = c2_q;
    assign c2_oe    = c2_mode[2];
    assign port_val = latch_en ? cap_q : port_in;
endmodule

// File: rtl/hsk_irq_regs.sv
// Interrupt flag and enable registers. Flags are set by one-cycle requests
// and cleared by request or by writing ones; a set beats a clear in the
// same cycle. The enable register uses a set/clear selector in the top bit.
module hsk_irq_regs #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic [NF-1:0] clr_vec,
    input  logic          flag_wr,
    input  logic          enab_wr,
    input  logic [NF:0]   wdata,
    output logic [NF-1:0] ifr_q,
    output logic [NF-1:0] ier_q,
    output logic          any_pend
);
    logic [NF-1:0] wclr;

    assign wclr = flag_wr ? wdata[NF-1:0] : '0;

    // Flag register update
    always_ff @(posedge clk) begin
        if (!rst_n) ifr_q <= '0;
        else        ifr_q <= (ifr_q & ~(clr_vec | wclr)) | set_vec;
    end

    // Enable register update through set/clear selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0;
        end else if (enab_wr) begin
            if (wdata[NF]) ier_q <= ier_q | wdata[NF-1:0];
            else           ier_q <= ier_q & ~wdata[NF-1:0];
        end
    end

    assign any_pend = |(ifr_q & ier_q);
endmodule

// File: rtl/hsk_port_ctrl.sv
// Top of the handshake port controller: register decode, port output
// registers, two control sides and the interrupt registers.
// Assumes single-cycle bus strobes and control inputs synchronous to clk.
module hsk_port_ctrl
    import hsk_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    input  logic              ca1_in,
    input  logic              ca2_in,
    output logic              ca2_out,
    output logic              ca2_oe,
    input  logic              cb1_in,
    input  logic              cb2_in,
    output logic              cb2_out,
    output logic              cb2_oe,
    input  logic              t1_evt,
    input  logic              t2_evt,
    input  logic              sr_evt,
    output logic              irq_n
);
    logic [PORT_W-1:0] pa_out_q;
    logic [PORT_W-1:0] pb_out_q;
    logic [REG_W-1:0]  ctrl_q;
    logic [NSIDE-1:0]  latch_q;

    logic              strobe;
    logic              acc_a;
    logic              acc_b;
    logic              flag_wr;
    logic              enab_wr;

    logic [NSIDE-1:0]  acc;
    logic [NSIDE-1:0]  c1_i;
    logic [NSIDE-1:0]  c2_i;
    logic [NSIDE-1:0]  c1_set;
    logic [NSIDE-1:0]  c2_set;
    logic [NSIDE-1:0]  c1_clr;
    logic [NSIDE-1:0]  c2_clr;
    logic [NSIDE-1:0]  c2_o;
    logic [NSIDE-1:0]  c2_e;
    logic [PORT_W-1:0] pin   [NSIDE];
    logic [PORT_W-1:0] pval  [NSIDE];

    logic [NFLAG-1:0]  set_vec;
    logic [NFLAG-1:0]  clr_vec;
    logic [NFLAG-1:0]  ifr;
    logic [NFLAG-1:0]  ier;
    logic              any_pend;

    // Address decode of strobes
    always_comb begin
        strobe  = bus_wr | bus_rd;
        acc_a   = strobe & (bus_addr == ADR_PORTA);
        acc_b   = strobe & (bus_addr == ADR_PORTB);
        flag_wr = bus_wr & (bus_addr == ADR_FLAG);
        enab_wr = bus_wr & (bus_addr == ADR_ENAB);
    end

    // Software-written registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_out_q <= '0;
            pb_out_q <= '0;
            ctrl_q   <= '0;
            latch_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_PORTA, ADR_PORTA_Q: pa_out_q <= bus_wdata[PORT_W-1:0];
                ADR_PORTB:              pb_out_q <= bus_wdata[PORT_W-1:0];
                ADR_CTRL:               ctrl_q   <= bus_wdata;
                ADR_LATCH:              latch_q  <= bus_wdata[NSIDE-1:0];
                default: ;
            endcase
        end
    end

    // Side 0 is A, side 1 is B
    assign acc  = {acc_b, acc_a};
    assign c1_i = {cb1_in, ca1_in};
    assign c2_i = {cb2_in, ca2_in};
    assign pin[0] = pa_in;
    assign pin[1] = pb_in;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        hsk_side #(.PORT_W(PORT_W)) u_side (
            .clk     (clk),
            .rst_n   (rst_n),
            .c1_in   (c1_i[s]),
            .c2_in   (c2_i[s]),
            .c1_rise (ctrl_q[4*s]),
            .c2_mode (ctrl_q[4*s+1 +: 3]),
            .latch_en(latch_q[s]),
            .port_in (pin[s]),
            .access  (acc[s]),
            .c1_set  (c1_set[s]),
            .c2_set  (c2_set[s]),
            .c1_clr  (c1_clr[s]),
            .c2_clr  (c2_clr[s]),
            .c2_out  (c2_o[s]),
            .c2_oe   (c2_e[s]),
            .port_val(pval[s])
        );
    end

    // Gather set and clear requests into flag positions
    always_comb begin
        set_vec         = '0;
        clr_vec         = '0;
        set_vec[FL_CA2] = c2_set[0];
        set_vec[FL_CA1] = c1_set[0];
        set_vec[FL_CB2] = c2_set[1];
        set_vec[FL_CB1] = c1_set[1];
        set_vec[FL_T1]  = t1_evt;
        set_vec[FL_T2]  = t2_evt;
        set_vec[FL_SR]  = sr_evt;
        clr_vec[FL_CA2] = c2_clr[0];
        clr_vec[FL_CA1] = c1_clr[0];
        clr_vec[FL_CB2] = c2_clr[1];
        clr_vec[FL_CB1] = c1_clr[1];
    end

    hsk_irq_regs #(.NF(NFLAG)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flag_wr (flag_wr),
        .enab_wr (enab_wr),
        .wdata   (bus_wdata),
        .ifr_q   (ifr),
        .ier_q   (ier),
        .any_pend(any_pend)
    );

    // Read data multiplexer
    always_comb begin
        case (bus_addr)
            ADR_PORTA, ADR_PORTA_Q: bus_rdata = REG_W'(pval[0]);
            ADR_PORTB:              bus_rdata = REG_W'(pval[1]);
            ADR_CTRL:               bus_rdata = ctrl_q;
            ADR_LATCH:              bus_rdata = REG_W'(latch_q);
            ADR_FLAG:               bus_rdata = {any_pend, ifr};
            ADR_ENAB:               bus_rdata = {1'b1, ier};
            default:                bus_rdata = '0;
        endcase
    end

    assign pa_out  = pa_out_q;
    assign pb_out  = pb_out_q;
    assign ca2_out = c2_o[0];
    assign ca2_oe  = c2_e[0];
    assign cb2_out = c2_o[1];
    assign cb2_oe  = c2_e[1];
    assign irq_n   = ~any_pend;
endmodule

// File: rtl/hsk_port_ctrl_chk.sv
// Property checker for the handshake port controller, bound to the top.
// Observes side A's C2 output against its mode and access strobe, the
// enable register after writes, and persistence of the CA1 flag.
module hsk_port_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_a,
    input logic [2:0] mode_a,
    input logic       ca2_out,
    input logic [6:0] ifr,
    input logic [6:0] ier,
    input logic       flag_wr,
    input logic       enab_wr,
    input logic [7:0] wdata
);
    a_r5_hsk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 3'b100 && acc_a) |=> !ca2_out);

    a_r6_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 3'b101 && acc_a) |=> !ca2_out);

    a_r6_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 3'b101 && !acc_a) |=> ca2_out);

    a_r7_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 3'b110) |=> !ca2_out);

    a_r7_fixed_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == 3'b111) |=> ca2_out);

    a_r10_enab_set: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_wr && wdata[7]) |=> ((ier & $past(wdata[6:0])) == $past(wdata[6:0])));

    a_r10_enab_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_wr && !wdata[7]) |=> ((ier & $past(wdata[6:0])) == 7'd0));

    a_r2_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ifr[1] && !acc_a && !flag_wr) |=> ifr[1]);
endmodule

bind hsk_port_ctrl hsk_port_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_a  (acc_a),
    .mode_a (ctrl_q[3:1]),
    .ca2_out(ca2_out),
    .ifr    (ifr),
    .ier    (ier),
    .flag_wr(flag_wr),
    .enab_wr(enab_wr),
    .wdata  (bus_wdata)
);

// File: tb/hsk_port_ctrl_bench.sv
// Directed bench: one task per scenario, inputs driven on falling edges.
module hsk_port_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h00;
    logic [7:0] pa_out;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pb_out;
    logic       ca1_in = 1'b1;
    logic       ca2_in = 1'b1;
    logic       ca2_out;
    logic       ca2_oe;
    logic       cb1_in = 1'b1;
    logic       cb2_in = 1'b1;
    logic       cb2_out;
    logic       cb2_oe;
    logic       t1_evt = 1'b0;
    logic       t2_evt = 1'b0;
    logic       sr_evt = 1'b0;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hsk_port_ctrl u_hsk_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pb_in(pb_in), .pb_out(pb_out),
        .ca1_in(ca1_in), .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe),
        .cb1_in(cb1_in), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe),
        .t1_evt(t1_evt), .t2_evt(t2_evt), .sr_evt(sr_evt), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 c2 outs", {6'd0, cb2_out, ca2_out}, 8'h03);
        chk("R1 c2 oe", {6'd0, cb2_oe, ca2_oe}, 8'h00);
        peek(4'hD, d); chk("R1 flags", d, 8'h00);
        peek(4'hE, d); chk("R1 enables", d, 8'h80);
    endtask

    task automatic t_c1_edges;
        logic [7:0] d;
        bus_write(4'hC, 8'h00);
        ca1_in = 1'b0; idle(1);
        peek(4'hD, d); chk("R2 CA1 falling sets", d & 8'h02, 8'h02);
        idle(3);
        peek(4'hD, d); chk("R2 CA1 flag held", d & 8'h02, 8'h02);
        bus_write(4'hD, 8'h02);
        ca1_in = 1'b1; idle(1);
        peek(4'hD, d); chk("R2 CA1 rising ignored", d & 8'h02, 8'h00);
        bus_write(4'hC, 8'h11);
        ca1_in = 1'b0; cb1_in = 1'b0; idle(1);
        peek(4'hD, d); chk("R2 falling ignored when rising chosen", d & 8'h12, 8'h00);
        ca1_in = 1'b1; cb1_in = 1'b1; idle(1);
        peek(4'hD, d); chk("R2 rising sets CA1 and CB1", d & 8'h12, 8'h12);
        bus_read(4'h1, d);
        peek(4'hD, d); chk("R4 port A read clears CA1 only", d & 8'h12, 8'h10);
        bus_write(4'h0, 8'hA5);
        peek(4'hD, d); chk("R4 port B write clears CB1", d & 8'h12, 8'h00);
        chk("R4 pb_out loaded", pb_out, 8'hA5);
    endtask

    task automatic t_c2_modes;
        logic [7:0] d;
        bus_write(4'hC, 8'h00);
        ca2_in = 1'b0; idle(1);
        peek(4'hD, d); chk("R3 mode 000 falling sets CA2", d & 8'h01, 8'h01);
        bus_read(4'h1, d);
        peek(4'hD, d); chk("R4 mode 000 access clears CA2", d & 8'h01, 8'h00);
        bus_write(4'hC, 8'h02);
        ca2_in = 1'b1; idle(1);
        peek(4'hD, d); chk("R3 mode 001 rising ignored", d & 8'h01, 8'h00);
        ca2_in = 1'b0; idle(1);
        bus_read(4'h1, d);
        peek(4'hD, d); chk("R3 mode 001 flag kept on access", d & 8'h01, 8'h01);
        bus_write(4'hD, 8'h01);
        bus_write(4'hC, 8'h60);
        cb2_in = 1'b0; idle(1);
        peek(4'hD, d); chk("R3 mode 011 falling ignored", d & 8'h08, 8'h00);
        cb2_in = 1'b1; idle(1);
        bus_write(4'h0, 8'h3C);
        peek(4'hD, d); chk("R3 mode 011 rising kept on access", d & 8'h08, 8'h08);
        bus_write(4'hD, 8'h08);
        bus_write(4'hC, 8'h40);
        cb2_in = 1'b0; idle(1);
        cb2_in = 1'b1; idle(1);
        peek(4'hD, d); chk("R3 mode 010 rising sets CB2", d & 8'h08, 8'h08);
        bus_write(4'h0, 8'h5A);
        peek(4'hD, d); chk("R4 mode 010 access clears CB2", d & 8'h08, 8'h00);
        chk("R7 input mode oe low", {6'd0, cb2_oe, ca2_oe}, 8'h00);
    endtask

    task automatic t_handshake;
        bus_write(4'hC, 8'h09);
        ca1_in = 1'b0; idle(1);
        chk("R5 idle high", {7'd0, ca2_out}, 8'h01);
        chk("R7 output mode oe", {7'd0, ca2_oe}, 8'h01);
        bus_write(4'h1, 8'h77);
        chk("R5 low after access", {7'd0, ca2_out}, 8'h00);
        chk("R4 pa_out loaded", pa_out, 8'h77);
        idle(4);
        chk("R5 stays low", {7'd0, ca2_out}, 8'h00);
        ca1_in = 1'b1; idle(1);
        chk("R5 high after C1 edge", {7'd0, ca2_out}, 8'h01);
        idle(2);
        chk("R5 remains high", {7'd0, ca2_out}, 8'h01);
        bus_write(4'hD, 8'h7F);
    endtask

    task automatic t_pulse;
        logic [7:0] d;
        bus_write(4'hC, 8'h0A);
        idle(1);
        bus_read(4'h1, d);
        chk("R6 low one cycle", {7'd0, ca2_out}, 8'h00);
        idle(1);
        chk("R6 back high", {7'd0, ca2_out}, 8'h01);
        idle(2);
        chk("R6 stays high", {7'd0, ca2_out}, 8'h01);
    endtask

    task automatic t_fixed;
        bus_write(4'hC, 8'h0C);
        idle(1);
        chk("R7 mode 110 low", {7'd0, ca2_out}, 8'h00);
        bus_write(4'hC, 8'h0E);
        idle(1);
        chk("R7 mode 111 high", {7'd0, ca2_out}, 8'h01);
        chk("R7 mode 111 oe", {7'd0, ca2_oe}, 8'h01);
    endtask

    task automatic t_quiet;
        logic [7:0] d;
        bus_write(4'hC, 8'h0A);
        ca1_in = 1'b1; idle(1);
        ca1_in = 1'b0; idle(1);
        bus_write(4'hF, 8'h5A);
        chk("R8 quiet write no pulse", {7'd0, ca2_out}, 8'h01);
        chk("R8 quiet write loads pa_out", pa_out, 8'h5A);
        bus_read(4'hF, d);
        chk("R8 quiet read no pulse", {7'd0, ca2_out}, 8'h01);
        peek(4'hD, d); chk("R8 CA1 flag survives", d & 8'h02, 8'h02);
        bus_write(4'hD, 8'h7F);
    endtask

    task automatic t_latch;
        logic [7:0] d;
        bus_write(4'hC, 8'h01);
        bus_write(4'hB, 8'h01);
        pa_in = 8'h11; pb_in = 8'h33;
        ca1_in = 1'b1; idle(1);
        pa_in = 8'h22; idle(1);
        bus_read(4'h1, d); chk("R9 latched value", d, 8'h11);
        bus_read(4'h0, d); chk("R9 port B live", d, 8'h33);
        bus_write(4'hB, 8'h00);
        bus_read(4'h1, d); chk("R9 unlatched live", d, 8'h22);
        bus_write(4'hD, 8'h7F);
    endtask

    task automatic pulse_evt(input logic a, input logic b, input logic c);
        t1_evt = a; t2_evt = b; sr_evt = c;
        @(negedge clk);
        t1_evt = 1'b0; t2_evt = 1'b0; sr_evt = 1'b0;
    endtask

    task automatic t_irq;
        logic [7:0] d;
        bus_write(4'hC, 8'h00);
        bus_write(4'hD, 8'h7F);
        pulse_evt(1'b1, 1'b0, 1'b0);
        peek(4'hD, d); chk("R11 T1 at bit 6, not enabled", d, 8'h40);
        chk("R12 irq_n high when disabled", {7'd0, irq_n}, 8'h01);
        bus_write(4'hE, 8'hC0);
        peek(4'hE, d); chk("R10 set T1 enable", d, 8'hC0);
        chk("R12 irq_n low", {7'd0, irq_n}, 8'h00);
        peek(4'hD, d); chk("R11 bit7 on", d, 8'hC0);
        bus_write(4'hE, 8'hA0);
        peek(4'hE, d); chk("R10 zeros leave enables", d, 8'hE0);
        bus_write(4'hE, 8'h40);
        peek(4'hE, d); chk("R10 clear T1 enable", d, 8'hA0);
        chk("R12 irq_n released", {7'd0, irq_n}, 8'h01);
        pulse_evt(1'b0, 1'b1, 1'b1);
        peek(4'hD, d); chk("R11 T2 bit5 SR bit2", d, 8'hE4);
        chk("R12 irq_n low on T2", {7'd0, irq_n}, 8'h00);
        bus_write(4'hD, 8'h20);
        peek(4'hD, d); chk("R11 write-one clear", d, 8'h44);
        chk("R12 irq_n high after clear", {7'd0, irq_n}, 8'h01);
        bus_write(4'hD, 8'h7F);
        peek(4'hD, d); chk("R11 all cleared", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_c1_edges();
        t_c2_modes();
        t_handshake();
        t_pulse();
        t_fixed();
        t_quiet();
        t_latch();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule